// File: doc/BRIEF.md
# Two-Wire Indexed and Block Register Slave

This block is a target on a two-wire serial bus, of the I2C/SMBus kind. It gives an external bus controller read and write access to a small bank of 8-bit configuration registers. The clock and data lines reach it already synchronized to the system clock. It pulls the data line low through an open-drain enable. The full register bank is presented on a flat parallel output, so neighbouring logic can use the settings directly.

The byte that follows the device address is the command. When its top bit is set, the low seven bits name one register, and that register is written or read on its own. When the top bit is clear, the transfer is counted and starts at register 0. A write first sends a count byte, which the slave acknowledges and discards, and then the data. A read begins with a repeated start. The slave then reports how many registers it holds and sends the registers in ascending order until the controller answers with a not-acknowledge.

Top module: `smb_regslave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal `DEV_ADDR` (default 7'h69, so 8'hD2 for a write and 8'hD3 for a read). Any other address is not acknowledged, and the bytes that follow it until the next start have no effect on the registers.
- R2: A command byte with bit 7 = 1 selects indexed access at offset `cmd[6:0]`. Each data byte written after it lands at that offset, and any further bytes land at the offsets that follow. A register takes its new value on the SCL falling edge that ends the eighth data bit, which is before the acknowledge clock pulse.
- R3: An indexed read is a write of the address, then the command with bit 7 set, then a repeated start and the read address. It returns the register at `cmd[6:0]`.
- R4: A command byte of 8'h00 selects a block write. The first byte after it is a count, which is acknowledged and not stored. The data bytes that follow go to registers 0, 1, 2 and onward.
- R5: A block read (command 8'h00, repeated start, read address) returns `NREG` as its first byte, then registers 0, 1, 2 and onward. The slave keeps sending while the controller acknowledges, and stops sending after a not-acknowledge.
- R6: Every byte is shifted MSB first. A stop after any complete data byte keeps all bytes received before it.
- R7: A write to an offset at or above `NREG` is acknowledged and changes no register. A read from such an offset returns 8'h00.
- R8: A start or stop in the middle of a byte abandons that byte without effect. After a start, the slave takes the next byte as an address.
- R9: The data enable changes only while SCL is low. After a stop, the slave has released the data line.
- R10: After reset, every register is 8'h00 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| regs_o | output | NREG*8 | Register bank; register k is at bits [8k+7:8k] |

## Verification
The bench builds the block with `NREG` = 6 and the default address. With six registers, the reported count differs from the usual power-of-two sizes. Offsets 6 to 127 become reachable as out-of-range targets, both for indexed access and for auto-increment that runs past the last register. Block reads that ask for more bytes than the bank holds cross the same boundary, as do block writes that stop early.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } smb_state_e;

  // upper seven bits of an address byte against the device address
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // register index inside a bank of n entries
  function automatic logic idx_ok(input logic [6:0] idx, input int unsigned n);
    return 32'(idx) < n;
  endfunction
endpackage

// File: rtl/smb_cond.sv
module smb_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = !scl_q && scl_i;
  assign scl_fall  = scl_q && !scl_i;
  assign bus_start = scl_q && scl_i && sda_q && !sda_i;
  assign bus_stop  = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/smb_bank.sv
module smb_bank #(
  parameter int unsigned NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [6:0]        wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [6:0]        rd_idx,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_o
);
  import smb_pkg::*;
  localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [7:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= 8'h00;
      else if (wr_en && wr_idx == 7'(g)) mem[g] <= wr_data;
    end
    assign regs_o[g*8 +: 8] = mem[g];
  end

  assign rd_data = idx_ok(rd_idx, NREG) ? mem[rd_idx[IW-1:0]] : 8'h00;
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl #(
  parameter int unsigned NREG     = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_i,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic [7:0] rd_data,
  output logic [6:0] rd_idx,
  output logic       wr_en,
  output logic [6:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  import smb_pkg::*;
  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  smb_state_e state;
  logic [2:0] bitcnt;
  logic       full;
  logic [7:0] rx_sh, tx_sh;
  logic       rw, blk, cnt_pend, mack;
  logic [6:0] ptr;

  logic       rx_state, byte_done, ld_cnt;
  logic [7:0] ld_byte;

  assign rx_state  = (state == S_ADDR) || (state == S_CMD) || (state == S_WDAT);
  assign byte_done = rx_state && scl_fall && full;
  assign ld_cnt    = blk && cnt_pend;
  assign ld_byte   = ld_cnt ? CNT_BYTE : rd_data;

  assign wr_en   = byte_done && (state == S_WDAT) && !ld_cnt && idx_ok(ptr, NREG);
  assign wr_idx  = ptr;
  assign wr_data = rx_sh;
  assign rd_idx  = ptr;

  assign sda_oe = (state == S_AACK) || (state == S_CACK) || (state == S_WACK) ||
                  ((state == S_RDAT) && !tx_sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      full     <= 1'b0;
      rx_sh    <= '0;
      tx_sh    <= 8'hFF;
      rw       <= 1'b0;
      blk      <= 1'b0;
      cnt_pend <= 1'b0;
      mack     <= 1'b1;
      ptr      <= '0;
    end else if (bus_stop) begin
      state <= S_IDLE;
      full  <= 1'b0;
    end else if (bus_start) begin
      state  <= S_ADDR;
      bitcnt <= '0;
      full   <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_CMD, S_WDAT: begin
          if (scl_rise && !full) begin
            rx_sh  <= {rx_sh[6:0], sda_i};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) full <= 1'b1;
          end else if (byte_done) begin
            full   <= 1'b0;
            bitcnt <= '0;
            if (state == S_ADDR) begin
              if (addr_hit(rx_sh, DEV_ADDR)) begin
                rw    <= rx_sh[0];
                state <= S_AACK;
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_CMD) begin
              blk      <= !rx_sh[7];
              cnt_pend <= !rx_sh[7];
              ptr      <= rx_sh[7] ? rx_sh[6:0] : 7'd0;
              state    <= S_CACK;
            end else begin
              if (ld_cnt) cnt_pend <= 1'b0;
              else        ptr      <= ptr + 7'd1;
              state <= S_WACK;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              tx_sh <= ld_byte;
              if (ld_cnt) cnt_pend <= 1'b0;
              else        ptr      <= ptr + 7'd1;
              state <= S_RDAT;
            end else begin
              state <= S_CMD;
            end
          end
        end
        S_CACK, S_WACK: if (scl_fall) state <= S_WDAT;
        S_RDAT: begin
          if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              bitcnt <= '0;
              state  <= S_RACK;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b1};
              bitcnt <= bitcnt + 3'd1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= sda_i;
          else if (scl_fall) begin
            if (!mack) begin
              tx_sh <= ld_byte;
              if (ld_cnt) cnt_pend <= 1'b0;
              else        ptr      <= ptr + 7'd1;
              state <= S_RDAT;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave #(
  parameter int unsigned NREG     = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  logic       scl_rise, scl_fall, bus_start, bus_stop;
  logic       wr_en;
  logic [6:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;

  smb_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  smb_ctrl #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_oe(sda_oe)
  );

  smb_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(regs_o)
  );
endmodule

// File: rtl/smb_chk.sv
module smb_chk #(
  parameter int unsigned NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              scl_fall,
  input logic              bus_stop,
  input logic              wr_en,
  input logic [6:0]        wr_idx,
  input logic [NREG*8-1:0] regs_o
);
  // R9: data enable only moves while the clock line is low
  p_sda_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));

  // R9: stop leaves the line released
  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_oe);

  // R7: no write strobe outside the bank
  p_wr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_idx) < NREG));

  // R2: writes land on the clock fall that closes the byte
  p_wr_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> scl_fall);

  // R2: registers change only after a write strobe
  p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(regs_o));
endmodule

bind smb_regslave smb_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .scl_fall(scl_fall), .bus_stop(bus_stop), .wr_en(wr_en),
  .wr_idx(wr_idx), .regs_o(regs_o)
);

// File: tb/test_smb_regslave.sv
module test_smb_regslave;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam int Q = 4;
  localparam logic [7:0] AW = 8'hD2;
  localparam logic [7:0] AR = 8'hD3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [N*8-1:0] regs_o;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [7:0] model [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_regslave #(.NREG(N)) i_smb_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  function automatic logic [7:0] exp_rd(input int off);
    return (off < N) ? model[off] : 8'h00;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    nchk++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < N; i++) check(req, regs_o[i*8 +: 8], model[i]);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_w(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bit_r(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic b_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic b_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_w(b[i]);
    bit_r(ack);
  endtask

  // R2 timing: value visible before the acknowledge clock pulse
  task automatic wbyte_peek(input logic [7:0] b, input int off, output logic ack);
    for (int i = 7; i >= 0; i--) bit_w(b[i]);
    if (off < N) check("R2 early", regs_o[off*8 +: 8], b);
    bit_r(ack);
  endtask

  task automatic rbyte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      logic x;
      bit_r(x);
      b[i] = x;
    end
    bit_w(nack);
  endtask

  task automatic op_bwrite(input int off, input logic [7:0] v);
    logic a;
    b_start;
    wbyte(AW, a); check("R1 ack", a, 0);
    wbyte({1'b1, 7'(off)}, a); check("R2 cmd ack", a, 0);
    wbyte_peek(v, off, a); check("R7 data ack", a, 0);
    b_stop;
    if (off < N) model[off] = v;
    check_regs("R2/R7 regs");
    check("R9 released", sda_oe, 0);
  endtask

  task automatic op_bread(input int off);
    logic a;
    logic [7:0] v;
    b_start;
    wbyte(AW, a);
    wbyte({1'b1, 7'(off)}, a);
    b_start;
    wbyte(AR, a); check("R1 read ack", a, 0);
    rbyte(v, 1'b1);
    b_stop;
    check("R3/R7 read", v, exp_rd(off));
  endtask

  task automatic op_blkwrite(input logic [7:0] cnt, input int n);
    logic a;
    logic [7:0] v;
    b_start;
    wbyte(AW, a);
    wbyte(8'h00, a);
    wbyte(cnt, a); check("R4 count ack", a, 0);
    for (int i = 0; i < n; i++) begin
      v = 8'($urandom);
      wbyte(v, a); check("R4 data ack", a, 0);
      if (i < N) model[i] = v;
    end
    b_stop;
    check_regs("R4/R6 block write");
  endtask

  task automatic op_blkread(input int n);
    logic a;
    logic [7:0] v;
    b_start;
    wbyte(AW, a);
    wbyte(8'h00, a);
    b_start;
    wbyte(AR, a);
    rbyte(v, n == 0);
    check("R5 count", v, N);
    for (int i = 0; i < n; i++) begin
      rbyte(v, i == n - 1);
      check("R5/R6 block data", v, exp_rd(i));
    end
    b_stop;
    check("R5 released", sda_oe, 0);
  endtask

  initial begin
    logic a;
    logic [7:0] v;
    void'($urandom(32'h5eed));
    for (int i = 0; i < N; i++) model[i] = 8'h00;
    tick(5);
    check("R10 oe", sda_oe, 0);
    check_regs("R10 regs");
    rst_n = 1'b1;
    tick(5);

    op_bwrite(2, 8'hA5);
    op_bread(2);
    op_bwrite(0, 8'h80);
    op_bwrite(5, 8'h01);
    op_bwrite(6, 8'h77);
    op_bwrite(100, 8'h33);
    op_bread(9);

    // R1: foreign address, following bytes ignored
    b_start;
    wbyte(8'hA4, a); check("R1 nack", a, 1);
    wbyte(8'h85, a); check("R1 idle", a, 1);
    wbyte(8'h55, a);
    b_stop;
    check_regs("R1 ignored");

    // R2: auto-increment across the end of the bank
    b_start;
    wbyte(AW, a); wbyte(8'h84, a);
    wbyte(8'h4D, a); wbyte(8'hB2, a); wbyte(8'hEE, a);
    check("R7 beyond ack", a, 0);
    b_stop;
    model[4] = 8'h4D; model[5] = 8'hB2;
    check_regs("R2 increment");

    // R8: start in the middle of a data byte, then a fresh write
    b_start;
    wbyte(AW, a); wbyte(8'h82, a);
    for (int i = 0; i < 4; i++) bit_w(1'b0);
    b_start;
    wbyte(AW, a); check("R8 readdress", a, 0);
    wbyte(8'h83, a); wbyte(8'h3C, a);
    b_stop;
    model[3] = 8'h3C;
    check_regs("R8 start abort");

    // R8: stop in the middle of a data byte
    b_start;
    wbyte(AW, a); wbyte(8'h81, a);
    for (int i = 0; i < 5; i++) bit_w(1'b1);
    b_stop;
    check_regs("R8 stop abort");

    op_blkwrite(8'd6, 6);
    op_blkwrite(8'd6, 3);
    op_blkread(N);
    op_blkread(N + 2);
    op_blkread(0);

    for (int k = 0; k < 40; k++) begin
      int t;
      t = int'($urandom_range(3, 0));
      case (t)
        0: op_bwrite(int'($urandom_range(8, 0)), 8'($urandom));
        1: op_bread(int'($urandom_range(8, 0)));
        2: op_blkwrite(8'($urandom), int'($urandom_range(N, 1)));
        default: op_blkread(int'($urandom_range(N + 1, 0)));
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule